// File: doc/BRIEF.md
# I2C Byte-Paced Master Transmitter

This block is a master-only transmit engine for a two-wire serial bus, paced one byte at a time by software through a small write port. The port has two targets: a control word and a data byte. Software first makes sure the bus-busy output is low. It then writes a control word that sets the master and transmit bits and also requests a START. The engine pulls SDA low while SCL stays high, marks the bus busy, and raises both the end-of-frame flag and the transmit-ready flag.

From then on, software writes one byte to the data target for each frame and clears the end-of-frame flag. The first byte is the 7-bit target address followed by the direction bit. Each frame is eight bits, most significant first, plus a ninth clock on which the target pulls SDA low to acknowledge. The engine samples that acknowledge, sets the end-of-frame flag and, if enabled, raises an interrupt. When no byte is waiting, it holds SCL low. A byte written while a frame is still shifting is kept and goes out as soon as that frame ends. A STOP request is carried out after all pending bytes have been sent.

Top module: `i2cm_tx`

## Requirements
- R1: After reset, scl_o and sda_o are 1, and bus_busy, eof_flag, tx_ready, nack and irq are all 0.
- R2: A control write (wr_sel=0) uses these bits: bit0 interrupt enable, bit1 master, bit2 transmit, bit3 busy command, bit4 start/stop control, bit5 end-of-frame flag. A START happens only when one control write carries busy=1, start/stop=0, master=1 and transmit=1 while bus_busy is 0. Any other control word leaves the bus lines and bus_busy unchanged.
- R3: A START drives sda_o low while scl_o stays high and sets bus_busy in the cycle after the write. DIV cycles later, scl_o goes low and eof_flag and tx_ready are set together.
- R4: Each frame sends the held byte most significant bit first. Every bit is valid on a rising edge of scl_o. On the ninth clock sda_o is released to 1. While scl_o stays high, sda_o changes only for a START or a STOP.
- R5: eof_flag is set on the same clock edge as the ninth rising edge of scl_o. At that edge nack takes the level of sda_i (0 means acknowledged, 1 means not acknowledged).
- R6: After a frame ends with no byte waiting, scl_o stays low and no further clock edges appear until a data write (wr_sel=1) arrives.
- R7: A data write clears tx_ready. tx_ready returns to 1 when the engine takes the byte into its shifter. A byte written while a frame is shifting is held and follows that frame with no gap, so all bytes appear on the bus in the order they were written.
- R8: While interrupt enable is 1, irq follows eof_flag one cycle later. While it is 0, irq stays 0.
- R9: A control write with bit5=0 clears eof_flag. The flag rises only because of a START or the end of a frame.
- R10: A control write with busy=0 and start/stop=0 while bus_busy is 1 requests a STOP. The STOP runs after the current frame and any held byte. SDA is driven low with SCL low, then SCL rises, then SDA rises while SCL is high. After that, bus_busy returns to 0 with both lines high.
- R11: Within a frame, successive rising edges of scl_o are 2*DIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the data byte |
| wr_data | input | NB | Write value |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_o | output | 1 | SCL level driven by the master (1 = released) |
| sda_o | output | 1 | SDA level driven by the master (1 = released) |
| bus_busy | output | 1 | High from START until STOP completes |
| eof_flag | output | 1 | End-of-frame / start-done flag |
| tx_ready | output | 1 | Data byte holder is free for a new write |
| nack | output | 1 | Acknowledge bit sampled in the last frame |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a STOP is only requested while bus_busy is high. They also assume that sda_i is driven by the target only on the ninth clock, and that otherwise it just reflects the master's own sda_o, so the acknowledge sample is the only point where it matters. The stimulus keeps to this. A bus model ANDs sda_o with an acknowledge pattern that is drawn at random per frame and applied only after the eighth rising SCL edge. Software writes are paced the way a driver would pace them: a data byte only once tx_ready is high, and a STOP only while the bus is busy. The random part varies byte values, acknowledge outcomes, and whether software lets SCL stretch or queues the next byte early.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_WAIT, ST_LOW, ST_HIGH, ST_STOP1, ST_STOP2, ST_STOP3
  } eng_st_t;

  // control word bit positions
  localparam int CB_IE   = 0;
  localparam int CB_MST  = 1;
  localparam int CB_TRS  = 2;
  localparam int CB_BUSY = 3;
  localparam int CB_SS   = 4;
  localparam int CB_FLAG = 5;
endpackage

// File: rtl/i2cm_div.sv
module i2cm_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt;

  assign tick = run && (cnt == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [NB-1:0] wr_data,
  input  logic          bus_busy,
  input  logic          ev_start,
  input  logic          ev_frame,
  input  logic          ack_bit,
  input  logic          take,
  input  logic          stop_take,
  output logic          start_req,
  output logic          stop_pend,
  output logic          dvalid,
  output logic [NB-1:0] dbuf,
  output logic          eof_flag,
  output logic          tx_ready,
  output logic          nack,
  output logic          irq
);
  logic ctl_wr, dat_wr, stop_req;
  logic ie_q, flag_q;

  assign ctl_wr    = wr_en && !wr_sel;
  assign dat_wr    = wr_en && wr_sel;
  assign start_req = ctl_wr && wr_data[CB_BUSY] && !wr_data[CB_SS] &&
                     wr_data[CB_MST] && wr_data[CB_TRS] && !bus_busy;
  assign stop_req  = ctl_wr && !wr_data[CB_BUSY] && !wr_data[CB_SS] && bus_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
      tx_ready  <= 1'b0;
      nack      <= 1'b0;
      irq       <= 1'b0;
      dvalid    <= 1'b0;
      dbuf      <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (ctl_wr) ie_q <= wr_data[CB_IE];

      if (ev_start || ev_frame)         flag_q <= 1'b1;
      else if (ctl_wr && !wr_data[CB_FLAG]) flag_q <= 1'b0;

      if (ev_frame) nack <= ack_bit;

      if (dat_wr) begin
        dbuf     <= wr_data;
        dvalid   <= 1'b1;
        tx_ready <= 1'b0;
      end else begin
        if (take) dvalid <= 1'b0;
        if (take || ev_start) tx_ready <= 1'b1;
      end

      if (stop_req)       stop_pend <= 1'b1;
      else if (stop_take) stop_pend <= 1'b0;

      irq <= ie_q && flag_q;
    end
  end

  assign eof_flag = flag_q;

  // R9: the flag only rises because the engine reported a start or frame end
  a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(ev_start || ev_frame));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start_req,
  input  logic          stop_pend,
  input  logic          dvalid,
  input  logic [NB-1:0] dbuf,
  input  logic          sda_i,
  output logic          run,
  output logic          scl_q,
  output logic          sda_q,
  output logic          busy_q,
  output logic          ev_start,
  output logic          ev_frame,
  output logic          ack_bit,
  output logic          take,
  output logic          stop_take
);
  localparam int CW = $clog2(NB + 1);

  eng_st_t        st;
  logic [NB-2:0]  sh;
  logic [CW-1:0]  bcnt;

  assign run       = !(st == ST_IDLE || st == ST_WAIT);
  assign ev_start  = (st == ST_START) && tick;
  assign ev_frame  = (st == ST_LOW) && tick && (bcnt == CW'(NB));
  assign ack_bit   = sda_i;
  assign take      = (st == ST_WAIT) && dvalid;
  assign stop_take = (st == ST_WAIT) && !dvalid && stop_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
      sh     <= '0;
      bcnt   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_req) begin
          st     <= ST_START;
          sda_q  <= 1'b0;
          busy_q <= 1'b1;
        end
        ST_START: if (tick) begin
          st    <= ST_WAIT;
          scl_q <= 1'b0;
        end
        ST_WAIT: if (dvalid) begin
          sh    <= dbuf[NB-2:0];
          sda_q <= dbuf[NB-1];
          bcnt  <= '0;
          st    <= ST_LOW;
        end else if (stop_pend) begin
          sda_q <= 1'b0;
          st    <= ST_STOP1;
        end
        ST_LOW: if (tick) begin
          scl_q <= 1'b1;
          st    <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          scl_q <= 1'b0;
          if (bcnt == CW'(NB)) begin
            st <= ST_WAIT;
          end else begin
            bcnt  <= bcnt + 1'b1;
            sda_q <= (bcnt == CW'(NB - 1)) ? 1'b1 : sh[NB-2];
            sh    <= {sh[NB-3:0], 1'b0};
            st    <= ST_LOW;
          end
        end
        ST_STOP1: if (tick) begin
          scl_q <= 1'b1;
          st    <= ST_STOP2;
        end
        ST_STOP2: if (tick) begin
          sda_q <= 1'b1;
          st    <= ST_STOP3;
        end
        ST_STOP3: if (tick) begin
          busy_q <= 1'b0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: SDA moves under a high SCL only when entering START or the STOP release
  a_r4_sda_quiet: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |->
      (st == ST_START || st == ST_STOP3));
endmodule

// File: rtl/i2cm_tx.sv
module i2cm_tx #(
  parameter int DIV = 4,
  parameter int NB  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [NB-1:0] wr_data,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          bus_busy,
  output logic          eof_flag,
  output logic          tx_ready,
  output logic          nack,
  output logic          irq
);
  logic          tick, run;
  logic          start_req, stop_pend, dvalid;
  logic [NB-1:0] dbuf;
  logic          ev_start, ev_frame, ack_bit, take, stop_take;

  i2cm_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  i2cm_regs #(.NB(NB)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bus_busy(bus_busy), .ev_start(ev_start), .ev_frame(ev_frame),
    .ack_bit(ack_bit), .take(take), .stop_take(stop_take),
    .start_req(start_req), .stop_pend(stop_pend), .dvalid(dvalid), .dbuf(dbuf),
    .eof_flag(eof_flag), .tx_ready(tx_ready), .nack(nack), .irq(irq)
  );

  i2cm_engine #(.NB(NB)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .start_req(start_req),
    .stop_pend(stop_pend), .dvalid(dvalid), .dbuf(dbuf), .sda_i(sda_i),
    .run(run), .scl_q(scl_o), .sda_q(sda_o), .busy_q(bus_busy),
    .ev_start(ev_start), .ev_frame(ev_frame), .ack_bit(ack_bit),
    .take(take), .stop_take(stop_take)
  );

  // R3: bus turns busy exactly when the START pattern appears
  a_r3_start_lines: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> (!sda_o && scl_o));

  // R10: bus is released with both lines high
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> (scl_o && sda_o));

  // R5: end of frame flag coincides with SCL high on the ninth clock
  a_r5_flag_on_rise: assert property (@(posedge clk) disable iff (rst)
    ev_frame |=> (scl_o && eof_flag));
endmodule

// File: tb/sim_i2cm_tx.sv
module sim_i2cm_tx;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sda_i, scl_o, sda_o, bus_busy, eof_flag, tx_ready, nack, irq;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  ack_pat [64];
  byte cap [64];
  byte sent [64];
  int  sent_n = 0;
  int  rif = 0, fidx = 0, starts = 0, stops = 0, rise_total = 0;
  int  cyc = 0, last_rise = 0;
  bit  prev_scl = 1, prev_sda = 1, in_stop = 0;
  byte cur = 0;

  assign sda_i = sda_o & ~((rif == 8) && ack_pat[fidx]);

  i2cm_tx #(.DIV(DIV), .NB(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .bus_busy(bus_busy),
    .eof_flag(eof_flag), .tx_ready(tx_ready), .nack(nack), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr_ctrl(input bit ie, input bit mst, input bit trs,
                         input bit bsy, input bit ss, input bit flg);
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_data = {2'b00, flg, ss, bsy, trs, mst, ie};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_dat(input byte b);
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = b;
    sent[sent_n] = b; sent_n++;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_flag();
    while (!eof_flag) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!tx_ready) @(negedge clk);
  endtask

  // bus monitor: sampled at the falling clock edge
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (scl_o && prev_scl && !sda_o && prev_sda) starts++;
      if (scl_o && prev_scl && sda_o && !prev_sda) stops++;
      if (scl_o && !prev_scl && !(in_stop && fidx == sent_n)) begin
        rise_total++;
        if (rif > 0) chk("R11 scl rise spacing", cyc - last_rise, 2 * DIV);
        last_rise = cyc;
        if (rif < 8) begin
          cur = {cur[6:0], sda_o};
          rif++;
        end else begin
          cap[fidx] = cur;
          chk("R5 flag at ninth rise", eof_flag, 1);
          chk("R5 nack sample", nack, !ack_pat[fidx]);
          chk("R4 sda released on ninth clock", sda_o, 1);
          fidx++;
          rif = 0;
        end
      end
      prev_scl = scl_o;
      prev_sda = sda_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int r0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) ack_pat[i] = ($urandom % 4) != 0;
    ack_pat[0] = 1; ack_pat[1] = 0; ack_pat[2] = 1;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl", scl_o, 1);     chk("R1 sda", sda_o, 1);
    chk("R1 busy", bus_busy, 0); chk("R1 flag", eof_flag, 0);
    chk("R1 ready", tx_ready, 0); chk("R1 nack", nack, 0);
    chk("R1 irq", irq, 0);

    // R2 incomplete start commands are ignored
    wr_ctrl(1, 0, 1, 1, 0, 0);
    wr_ctrl(1, 1, 1, 1, 1, 0);
    repeat (3 * DIV) @(negedge clk);
    chk("R2 no start busy", bus_busy, 0);
    chk("R2 no start sda", sda_o, 1);
    chk("R2 no start count", starts, 0);

    // R3 start condition
    wr_ctrl(1, 1, 1, 1, 0, 0);
    chk("R3 sda low", sda_o, 0);
    chk("R3 scl high", scl_o, 1);
    chk("R3 busy", bus_busy, 1);
    chk("R3 flag not yet", eof_flag, 0);
    repeat (DIV) @(negedge clk);
    chk("R3 scl low", scl_o, 0);
    chk("R3 flag", eof_flag, 1);
    chk("R3 ready", tx_ready, 1);
    chk("R3 start seen", starts, 1);
    @(negedge clk);
    chk("R8 irq with enable", irq, 1);

    // directed frames: address then two bytes, stretched between frames
    for (int k = 0; k < 3; k++) begin
      int rt;
      wr_dat((k == 0) ? 8'hB4 : (k == 1 ? 8'h81 : 8'h3C));
      chk("R7 ready cleared by write", tx_ready, 0);
      wr_ctrl(1, 1, 1, 1, 1, 0);
      chk("R9 flag cleared", eof_flag, 0);
      wait_flag();
      @(negedge clk);
      chk("R8 irq follows flag", irq, 1);
      rt = rise_total;
      repeat (6 * DIV) @(negedge clk);
      chk("R6 scl held low", scl_o, 0);
      chk("R6 no extra edges", rise_total, rt);
    end

    // STOP
    in_stop = 1;
    wr_ctrl(1, 1, 1, 0, 0, 1);
    while (bus_busy) @(negedge clk);
    in_stop = 0;
    chk("R10 stop seen", stops, 1);
    chk("R10 scl idle", scl_o, 1);
    chk("R10 sda idle", sda_o, 1);

    // second transfer, interrupts off, random pacing
    wr_ctrl(0, 1, 1, 1, 0, 0);
    wait_flag();
    for (int k = 0; k < 12; k++) begin
      wait_ready();
      if ($urandom % 2 == 1) begin
        wait_flag();
        r0 = $urandom % 20;
        repeat (r0) @(negedge clk);
      end
      wr_dat((k == 0) ? 8'h6E : byte'($urandom));
      wr_ctrl(0, 1, 1, 1, 1, 0);
      chk("R8 irq stays low", irq, 0);
    end
    // last byte held behind a shifting frame, then STOP queued at once
    wait_ready();
    wr_dat(8'hA5);
    in_stop = 1;
    wr_ctrl(0, 1, 1, 0, 0, 1);
    while (bus_busy) @(negedge clk);
    in_stop = 0;
    chk("R10 held byte sent before stop", fidx, sent_n);
    chk("R10 second stop", stops, 2);
    chk("R10 lines idle", scl_o & sda_o, 1);

    for (int i = 0; i < sent_n; i++)
      chk($sformatf("R4 R7 byte %0d", i), int'(cap[i]) & 255, int'(sent[i]) & 255);

    finish_up();
  end
endmodule